// File: doc/BRIEF.md
# USB High-Speed Chirp Sequence Validator

This block sits next to the link controller of a high-speed USB device while the bus is held in reset. It watches the 2-bit line-state output of the transceiver and decides whether the upstream hub port replies with a proper alternating chirp pattern. The chirps are too slow to pass through the serial receive path, so the block works only on sampled line-state.

The line-state input is unfiltered. The block therefore times how long each level persists, and a level counts only after it has stayed unchanged for a qualifying number of clocks. The default is 150 clocks, which is 2.5 µs at 60 MHz. The sequence logic expects K and J in turn. It counts each accepted chirp, and it stops on the sixth chirp or on an accepted SE0.

The controller pulses `start` when it begins listening. When the sequence ends, the block returns a one-cycle verdict pulse and then stays idle until the next `start`.

Top module: `chirp_validator`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `chirp_valid`, `chirp_invalid` and `busy` are all low.
- R2: A `start` sampled high at a clock edge makes `busy` high from that edge on. It clears the chirp count and makes the block wait for K. A `start` that arrives while `busy` is high abandons the sequence in progress.
- R3: A line level is accepted only once it has been captured on QUAL_CYC consecutive clock edges. A run of QUAL_CYC-1 edges is never accepted. A run longer than QUAL_CYC is accepted only once.
- R4: Line-state encoding is 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1. SE1 is never accepted. Like any change of level, SE1 restarts the qualification run.
- R5: While waiting for K, an accepted J is ignored. While waiting for J, an accepted K is ignored. Each accepted expected level adds one to the chirp count and switches the expected level.
- R6: When the sixth chirp is accepted, `chirp_valid` is high for exactly one cycle. It rises at the clock edge after the edge that captured the QUAL_CYC-th sample of that chirp.
- R7: An accepted SE0 while `busy` is high, before six chirps, gives a one-cycle `chirp_invalid` pulse with the same latency as R6.
- R8: `busy` falls in the same cycle that a verdict pulse rises. While `busy` is low, no line activity produces a pulse.
- R9: `start` restarts the qualification run. A level that was already present counts only after QUAL_CYC edges, with the `start` edge counted as the first.
- R10: `chirp_valid` and `chirp_invalid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (60 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins chirp detection |
| line_state | input | 2 | Transceiver line-state: 00 SE0, 01 J, 10 K, 11 SE1 |
| chirp_valid | output | 1 | One-cycle pulse: six alternating chirps seen |
| chirp_invalid | output | 1 | One-cycle pulse: SE0 ended the sequence early |
| busy | output | 1 | High while a detection is in progress |

## Verification
Wrong internal state has different symptoms at the ports:
- A miscounted chirp or a wrong expected level shows as a verdict pulse that is missing or arrives one chirp early or late. A chirp lasts at least QUAL_CYC cycles, so the error is visible as a whole chirp period of difference.
- A qualification timer that is off by one moves every verdict by exactly one cycle, and it accepts or rejects runs of exactly QUAL_CYC-1 or QUAL_CYC samples.
- A stuck phase shows as `busy` failing to drop, or as a pulse while idle.

The bench compares all three outputs on every clock against a behavioural model, so any such error is reported in the cycle where it first appears.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_WANT_K = 2'b01,
        PH_WANT_J = 2'b10
    } phase_e;

    // Output of the level qualifier: a one-cycle hit with the accepted level.
    typedef struct packed {
        logic  hit;
        line_e lvl;
    } qual_t;

    // The verdict produced by the sequencer in one cycle.
    typedef struct packed {
        logic ok;
        logic bad;
    } verdict_t;

    function automatic line_e wanted_level(phase_e ph);
        return (ph == PH_WANT_J) ? LS_J : LS_K;
    endfunction

    function automatic phase_e other_phase(phase_e ph);
        return (ph == PH_WANT_K) ? PH_WANT_J : PH_WANT_K;
    endfunction

endpackage

// File: rtl/chirp_qual.sv
module chirp_qual
    import chirp_pkg::*;
#(
    parameter int QUAL_CYC = 150
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  line_e line_in,
    output qual_t qual
);
    localparam int RUN_W = $clog2(QUAL_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(QUAL_CYC);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(QUAL_CYC + 1);

    line_e            samp_q;
    logic [RUN_W-1:0] run_q;

    // run_q holds how many consecutive edges have captured samp_q.
    // It stops one past the hit value, so each run is accepted only once.
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= LS_SE1;
            run_q  <= '0;
        end else begin
            samp_q <= line_in;
            if (restart || (line_in != samp_q))
                run_q <= RUN_W'(1);
            else if (run_q != RUN_SAT)
                run_q <= run_q + RUN_W'(1);
        end
    end

    always_comb begin
        qual.lvl = samp_q;
        qual.hit = (run_q == RUN_HIT) && (samp_q != LS_SE1);
    end

endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_pkg::*;
#(
    parameter int CHIRPS = 6,
    localparam int CNT_W = $clog2(CHIRPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  qual_t            qual,
    output verdict_t         verdict,
    output logic             busy,
    output logic [CNT_W-1:0] chirp_cnt
);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(CHIRPS);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    verdict_t         verdict_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             take_data;
    logic             take_se0;

    always_comb begin
        cnt_inc   = cnt_q + CNT_W'(1);
        take_data = (phase_q != PH_IDLE) && qual.hit
                    && (qual.lvl == wanted_level(phase_q));
        take_se0  = (phase_q != PH_IDLE) && qual.hit && (qual.lvl == LS_SE0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            verdict_q <= '0;
        end else begin
            verdict_q <= '0;
            if (start) begin
                phase_q <= PH_WANT_K;
                cnt_q   <= '0;
            end else if (take_se0) begin
                verdict_q.bad <= 1'b1;
                phase_q       <= PH_IDLE;
            end else if (take_data) begin
                cnt_q <= cnt_inc;
                if (cnt_inc == CNT_DONE) begin
                    verdict_q.ok <= 1'b1;
                    phase_q      <= PH_IDLE;
                end else begin
                    phase_q <= other_phase(phase_q);
                end
            end
        end
    end

    assign verdict   = verdict_q;
    assign busy      = (phase_q != PH_IDLE);
    assign chirp_cnt = cnt_q;

endmodule

// File: rtl/chirp_validator.sv
module chirp_validator
    import chirp_pkg::*;
#(
    parameter int QUAL_CYC = 150,
    parameter int CHIRPS   = 6,
    localparam int CNT_W   = $clog2(CHIRPS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] line_state,
    output logic       chirp_valid,
    output logic       chirp_invalid,
    output logic       busy
);
    qual_t            qual;
    verdict_t         verdict;
    logic [CNT_W-1:0] chirp_cnt;

    chirp_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .line_in (line_e'(line_state)),
        .qual    (qual)
    );

    chirp_seq #(.CHIRPS(CHIRPS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .qual      (qual),
        .verdict   (verdict),
        .busy      (busy),
        .chirp_cnt (chirp_cnt)
    );

    assign chirp_valid   = verdict.ok;
    assign chirp_invalid = verdict.bad;

endmodule

// File: rtl/chirp_validator_chk.sv
module chirp_validator_chk #(
    parameter int CHIRPS = 6,
    localparam int CNT_W = $clog2(CHIRPS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             chirp_valid,
    input logic             chirp_invalid,
    input logic             busy,
    input logic [CNT_W-1:0] chirp_cnt
);
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(chirp_valid && chirp_invalid)); // R10
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        chirp_valid |=> !chirp_valid); // R6
    AST_INVALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        chirp_invalid |=> !chirp_invalid); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R2
    AST_VERDICT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (chirp_valid || chirp_invalid) |-> !busy); // R8
    AST_VERDICT_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        (chirp_valid || chirp_invalid) |-> ($past(busy) && !$past(start))); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        chirp_cnt <= CNT_W'(CHIRPS)); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (chirp_cnt == '0)); // R2
endmodule

bind chirp_validator chirp_validator_chk #(.CHIRPS(CHIRPS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .chirp_valid   (chirp_valid),
    .chirp_invalid (chirp_invalid),
    .busy          (busy),
    .chirp_cnt     (chirp_cnt)
);

// File: tb/chirp_validator_test.sv
module chirp_validator_test;
    localparam int QUAL = 150;
    localparam int LONG = QUAL + 10;
    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] line_state = SE1;
    logic       chirp_valid, chirp_invalid, busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int n_valid  = 0;
    int n_invalid = 0;

    // behavioural reference state
    int m_lvl = 3, m_held = 0, m_phase = 0, m_seen = 0;
    bit m_ok = 0, m_bad = 0;

    always #2 clk = ~clk;

    chirp_validator #(.QUAL_CYC(QUAL)) uut (
        .clk(clk), .rst(rst), .start(start), .line_state(line_state),
        .chirp_valid(chirp_valid), .chirp_invalid(chirp_invalid), .busy(busy)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1 waiting for K, 2 waiting for J.
    always @(posedge clk) begin
        if (rst) begin
            m_lvl = 3; m_held = 0; m_phase = 0; m_seen = 0; m_ok = 0; m_bad = 0;
        end else begin
            bit accepted;
            accepted = (m_held == QUAL) && (m_lvl != 3);
            m_ok = 0; m_bad = 0;
            if (start) begin
                m_phase = 1; m_seen = 0;
            end else if (m_phase != 0 && accepted) begin
                if (m_lvl == 0) begin
                    m_bad = 1; m_phase = 0;
                end else if ((m_phase == 1 && m_lvl == 2) || (m_phase == 2 && m_lvl == 1)) begin
                    m_seen++;
                    if (m_seen == 6) begin m_ok = 1; m_phase = 0; end
                    else m_phase = 3 - m_phase;
                end
            end
            if (start || int'(line_state) != m_lvl) m_held = 1;
            else if (m_held <= QUAL) m_held++;
            m_lvl = int'(line_state);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(chirp_valid == m_ok, "R6 valid", chirp_valid, m_ok);
            check(chirp_invalid == m_bad, "R7 invalid", chirp_invalid, m_bad);
            check(busy == (m_phase != 0), "R2 busy", busy, m_phase != 0);
            if (chirp_valid) n_valid++;
            if (chirp_invalid) n_invalid++;
        end
    end

    task automatic hold(input logic [1:0] lvl, input int n);
        line_state = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic six(input int len);
        for (int i = 0; i < 3; i++) begin
            hold(K, len);
            hold(J, len);
        end
    endtask

    task automatic expect_counts(input int v, input int b, input string rv, input string rb);
        check(n_valid == v, rv, n_valid, v);
        check(n_invalid == b, rb, n_invalid, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!chirp_valid && !chirp_invalid && !busy, "R1 reset outputs", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!chirp_valid && !chirp_invalid && !busy, "R1 after reset", busy, 0);

        // R2/R6: clean sequence
        kick();
        check(busy, "R2 busy after start", busy, 1);
        six(LONG);
        hold(SE0, 4);
        expect_counts(1, 0, "R6 one valid", "R6 no invalid");
        check(!busy, "R8 idle after valid", busy, 0);

        // R3: exact boundary lengths
        kick();
        six(QUAL);
        hold(SE1, 4);
        expect_counts(2, 0, "R3 exact QUAL accepted", "R3 no invalid");

        // R3: runs one short are never accepted; then SE0 ends it (R7)
        kick();
        for (int i = 0; i < 4; i++) begin hold(K, QUAL - 1); hold(J, QUAL - 1); end
        check(busy, "R3 short runs ignored", busy, 1);
        hold(SE0, LONG);
        expect_counts(2, 1, "R7 no valid", "R7 SE0 invalid");

        // R7: SE0 after three chirps
        kick();
        hold(K, LONG); hold(J, LONG); hold(K, LONG);
        hold(SE0, LONG);
        expect_counts(2, 2, "R7 no valid", "R7 invalid after three");

        // R4/R5: SE1 splits a K; J ignored while waiting for K
        kick();
        hold(K, 100); hold(SE1, 1); hold(K, 100);
        hold(J, LONG);
        check(busy, "R5 wrong level ignored", busy, 1);
        hold(SE1, LONG);
        check(busy, "R4 SE1 never accepted", busy, 1);
        six(LONG);
        hold(SE1, 4);
        expect_counts(3, 2, "R4 valid after SE1 split", "R5 no invalid");

        // R2: restart mid-sequence
        kick();
        hold(K, LONG); hold(J, LONG); hold(K, LONG); hold(J, LONG);
        kick();
        hold(K, LONG); hold(J, LONG);
        check(busy && n_valid == 3, "R2 restart cleared count", n_valid, 3);
        hold(K, LONG); hold(J, LONG); hold(K, LONG); hold(J, LONG);
        hold(SE1, 4);
        expect_counts(4, 2, "R2 valid after restart", "R2 no invalid");

        // R8: idle activity is ignored
        six(LONG);
        hold(SE0, LONG);
        expect_counts(4, 2, "R8 idle valid", "R8 idle invalid");
        check(!busy, "R8 idle busy", busy, 0);

        // R9: level held before start needs a fresh run
        hold(K, 300);
        kick();
        hold(K, QUAL - 3);
        hold(J, LONG);
        check(busy, "R9 early K not counted", busy, 1);
        six(LONG);
        hold(SE1, 4);
        expect_counts(5, 2, "R9 valid", "R10 no invalid");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule